// File: doc/BRIEF.md
# Bus Bit-Time Timestamp Counter

This block keeps a free-running 16-bit count of bus bit times and uses it to stamp frames. The count advances once for every bit period that a bit-timing unit flags, whether that bit belongs to a frame or to idle bus time. It stands still while the controller is frozen, and it wraps from its top value back to zero. When a frame decoder reports that a frame's identifier field is starting, the current count is latched. When the decoder later reports that the frame finished without error, the latched value is presented for one cycle to the message storage as that frame's timestamp.

Software reaches the count through a single read/write register in the host clock domain. A read returns a synchronized copy of the count. A write does not reach the counter at once. The new value is placed in a staging register in the host domain, and a level request/acknowledge handshake carries it into the bit-clock domain. A busy flag shows the handshake in progress, and software can poll the register to see when its value has landed.

Top module: `bitstamp_timer`

## Requirements
- R1: After reset the count is 0x0000, the register reads 0x00000000, `hostBusy` is 0, `stampValid` is 0 and `stampOut` is 0x0000.
- R2: Each `busClk` edge with `bitTick` high and `freeze` low adds one to the count.
- R3: Counting up from 0xFFFF gives 0x0000.
- R4: While `freeze` is high the count holds its value and `bitTick` has no effect.
- R5: A `busClk` edge with `idStart` high latches the count as it stood before that edge, even if a tick lands on the same edge.
- R6: A `busClk` edge with `frameOk` high makes `stampValid` high for exactly the next cycle, with `stampOut` equal to the value latched before that edge. `stampOut` holds its value at all other times.
- R7: A host write (`hostWrEn` high, `hostAddr` = 0x08, `hostBusy` low) stores `hostWrData` and raises `hostBusy` on the next `hostClk` edge. After a two-flop synchronized four-phase request/acknowledge sequence the count takes the written value, and `hostBusy` falls only after the acknowledge has dropped again.
- R8: A host write while `hostBusy` is high is ignored. The value in flight is the one that reaches the count.
- R9: A read with `hostAddr` = 0x08 returns the count in bits 15:0 and zero in bits 31:16 once the count has been stable for a few host cycles. Reads at any other address return zero. Writes to any other address are ignored and do not raise `hostBusy`.
- R10: When the handshake load and a counting tick fall on the same `busClk` edge, the count takes the written value.
- R11: A host write takes effect while `freeze` is high, and the loaded value is then held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Host register clock |
| busClk | input | 1 | Bit-timing domain clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 8 | Host register address |
| hostWrData | input | 16 | Host write value for the count |
| hostRdData | output | 32 | Host read data |
| hostBusy | output | 1 | Write handshake in progress |
| bitTick | input | 1 | One bus bit time has elapsed |
| freeze | input | 1 | Freeze mode, holds the count |
| idStart | input | 1 | Identifier field of a frame begins |
| frameOk | input | 1 | Frame completed successfully |
| stampValid | output | 1 | Timestamp presented this cycle |
| stampOut | output | 16 | Timestamp of the completed frame |

## Verification
The bench drives an identifier start together with a tick. A design that latched after the increment would report a stamp one too high. It also drives an identifier start in the same cycle as a frame completion, where a design that forwarded the new latch would stamp the earlier frame with the later frame's time. It writes just below the top value and ticks across the wrap, which exposes a counter that saturates or carries into unused bits. It also sends a second write during the handshake, to a wrong address, and under freeze. A design that dropped busy early, decoded the address loosely, or blocked loads in freeze would return the wrong value when the register is read back.

// File: rtl/bst_pkg.sv
package bst_pkg;

  // Strobes from control to datapath, all in the bus domain
  typedef struct packed {
    logic load;     // take staged host value into the count
    logic advance;  // add one to the count
    logic capture;  // latch the count as a stamp
    logic publish;  // present the latched stamp
  } bstStrobes_t;

  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_REQ   = 2'd1,
    HS_DRAIN = 2'd2
  } hsState_t;

endpackage

// File: rtl/bst_sync.sv
module bst_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[i] <= '0;
          else       stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/bst_ctrl.sv
module bst_ctrl
  import bst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        hostClk,
  input  logic        busClk,
  input  logic        rstN,
  input  logic        writeHit,
  output logic        acceptWr,
  output logic        busy,
  input  logic        bitTick,
  input  logic        freeze,
  input  logic        idStart,
  input  logic        frameOk,
  output bstStrobes_t strobes
);

  hsState_t hsState;
  logic     reqLvl;
  logic     ackSync;
  logic     reqSync;
  logic     ackLvl;

  assign acceptWr = writeHit && (hsState == HS_IDLE);
  assign busy     = (hsState != HS_IDLE);
  assign reqLvl   = (hsState == HS_REQ);

  // Host side of the four-phase handshake
  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN) begin
      hsState <= HS_IDLE;
    end else begin
      case (hsState)
        HS_IDLE:  if (acceptWr) hsState <= HS_REQ;
        HS_REQ:   if (ackSync)  hsState <= HS_DRAIN;
        HS_DRAIN: if (!ackSync) hsState <= HS_IDLE;
        default:  hsState <= HS_IDLE;
      endcase
    end
  end

  bst_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uReqSync (
    .clk(busClk), .rstN(rstN), .d(reqLvl), .q(reqSync)
  );

  // Bus side: acknowledge follows the synchronized request
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) ackLvl <= 1'b0;
    else       ackLvl <= reqSync;
  end

  bst_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) uAckSync (
    .clk(hostClk), .rstN(rstN), .d(ackLvl), .q(ackSync)
  );

  always_comb begin
    strobes.load    = reqSync && !ackLvl;
    strobes.advance = bitTick && !freeze && !strobes.load;
    strobes.capture = idStart;
    strobes.publish = frameOk;
  end

endmodule

// File: rtl/bst_datapath.sv
module bst_datapath
  import bst_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             hostClk,
  input  logic             busClk,
  input  logic             rstN,
  input  logic             acceptWr,
  input  logic [CNT_W-1:0] hostWrData,
  output logic [CNT_W-1:0] readCount,
  input  bstStrobes_t      strobes,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] auxVal,
  output logic [CNT_W-1:0] capVal,
  output logic             stampValid,
  output logic [CNT_W-1:0] stampOut
);

  logic [CNT_W-1:0] grayBus;
  logic [CNT_W-1:0] grayHost;

  function automatic logic [CNT_W-1:0] grayToBin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int k = CNT_W - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  // Staging register, host domain; held while the handshake runs
  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN)         auxVal <= '0;
    else if (acceptWr) auxVal <= hostWrData;
  end

  // Counter, bus domain; a load takes priority over a tick
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (strobes.load)    count <= auxVal;
    else if (strobes.advance) count <= count + 1'b1;
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN)                capVal <= '0;
    else if (strobes.capture) capVal <= count;
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      stampValid <= 1'b0;
      stampOut   <= '0;
    end else begin
      stampValid <= strobes.publish;
      if (strobes.publish) stampOut <= capVal;
    end
  end

  // Gray-coded copy of the count for the host read path
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) grayBus <= '0;
    else       grayBus <= count ^ (count >> 1);
  end

  bst_sync #(.WIDTH(CNT_W), .STAGES(SYNC_STAGES)) uReadSync (
    .clk(hostClk), .rstN(rstN), .d(grayBus), .q(grayHost)
  );

  assign readCount = grayToBin(grayHost);

endmodule

// File: rtl/bitstamp_timer.sv
module bitstamp_timer
  import bst_pkg::*;
#(
  parameter int          CNT_W       = 16,
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  REG_OFFSET  = 8'h08,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              hostClk,
  input  logic              busClk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [CNT_W-1:0]  hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostBusy,
  input  logic              bitTick,
  input  logic              freeze,
  input  logic              idStart,
  input  logic              frameOk,
  output logic              stampValid,
  output logic [CNT_W-1:0]  stampOut
);

  localparam int PAD_W = DATA_W - CNT_W;

  bstStrobes_t      strobes;
  logic             addrHit;
  logic             writeHit;
  logic             acceptWr;
  logic             loadPulse;
  logic [CNT_W-1:0] readCount;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] auxVal;
  logic [CNT_W-1:0] capVal;

  assign addrHit    = (hostAddr == ADDR_W'(REG_OFFSET));
  assign writeHit   = hostWrEn && addrHit;
  assign hostRdData = addrHit ? {{PAD_W{1'b0}}, readCount} : '0;
  assign loadPulse  = strobes.load;

  bst_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .hostClk(hostClk), .busClk(busClk), .rstN(rstN),
    .writeHit(writeHit), .acceptWr(acceptWr), .busy(hostBusy),
    .bitTick(bitTick), .freeze(freeze), .idStart(idStart),
    .frameOk(frameOk), .strobes(strobes)
  );

  bst_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .hostClk(hostClk), .busClk(busClk), .rstN(rstN),
    .acceptWr(acceptWr), .hostWrData(hostWrData), .readCount(readCount),
    .strobes(strobes), .count(count), .auxVal(auxVal), .capVal(capVal),
    .stampValid(stampValid), .stampOut(stampOut)
  );

endmodule

// File: rtl/bst_checker.sv
module bst_checker #(
  parameter int CNT_W = 16
) (
  input logic             hostClk,
  input logic             busClk,
  input logic             rstN,
  input logic             bitTick,
  input logic             freeze,
  input logic             idStart,
  input logic             frameOk,
  input logic             loadPulse,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] auxVal,
  input logic [CNT_W-1:0] capVal,
  input logic             stampValid,
  input logic [CNT_W-1:0] stampOut,
  input logic             hostBusy,
  input logic             writeHit
);

  a_r2_tick_adds_one: assert property (@(posedge busClk) disable iff (!rstN)
    (bitTick && !freeze && !loadPulse) |=> count == CNT_W'($past(count) + 1'b1));

  a_r3_wrap_zero: assert property (@(posedge busClk) disable iff (!rstN)
    (bitTick && !freeze && !loadPulse && count == {CNT_W{1'b1}}) |=> count == '0);

  a_r4_freeze_hold: assert property (@(posedge busClk) disable iff (!rstN)
    (freeze && !loadPulse) |=> $stable(count));

  a_r5_capture_prior: assert property (@(posedge busClk) disable iff (!rstN)
    idStart |=> capVal == $past(count));

  a_r6_publish: assert property (@(posedge busClk) disable iff (!rstN)
    frameOk |=> (stampValid && stampOut == $past(capVal)));

  a_r6_quiet: assert property (@(posedge busClk) disable iff (!rstN)
    !frameOk |=> (!stampValid && $stable(stampOut)));

  a_r10_load_wins: assert property (@(posedge busClk) disable iff (!rstN)
    loadPulse |=> count == $past(auxVal));

  a_r7_busy_rises: assert property (@(posedge hostClk) disable iff (!rstN)
    (writeHit && !hostBusy) |=> hostBusy);

  a_r8_busy_blocks: assert property (@(posedge hostClk) disable iff (!rstN)
    hostBusy |=> $stable(auxVal));

endmodule

bind bitstamp_timer bst_checker #(.CNT_W(CNT_W)) uChk (
  .hostClk(hostClk), .busClk(busClk), .rstN(rstN),
  .bitTick(bitTick), .freeze(freeze), .idStart(idStart), .frameOk(frameOk),
  .loadPulse(loadPulse), .count(count), .auxVal(auxVal), .capVal(capVal),
  .stampValid(stampValid), .stampOut(stampOut),
  .hostBusy(hostBusy), .writeHit(writeHit)
);

// File: tb/sim_bitstamp_timer.sv
`timescale 1ns/1ps
module sim_bitstamp_timer;

  logic        hostClk = 1'b0;
  logic        busClk  = 1'b0;
  logic        rstN    = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostAddr = 8'h08;
  logic [15:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        hostBusy;
  logic        bitTick = 1'b0;
  logic        freeze  = 1'b0;
  logic        idStart = 1'b0;
  logic        frameOk = 1'b0;
  logic        stampValid;
  logic [15:0] stampOut;

  int testsRun = 0;
  int testsFailed = 0;
  int stampsSeen = 0;
  int stampsPushed = 0;
  bit finished = 1'b0;
  logic [15:0] expQ [$];

  always #2 hostClk = ~hostClk;   // 250 MHz
  always #3 busClk  = ~busClk;

  bitstamp_timer u0 (
    .hostClk(hostClk), .busClk(busClk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .hostBusy(hostBusy),
    .bitTick(bitTick), .freeze(freeze), .idStart(idStart), .frameOk(frameOk),
    .stampValid(stampValid), .stampOut(stampOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge busClk);
    bitTick = 1'b1;
    repeat (n) @(negedge busClk);
    bitTick = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] addr, output logic [31:0] val);
    repeat (12) @(negedge hostClk);
    hostAddr = addr;
    #0.5;
    val = hostRdData;
    hostAddr = 8'h08;
  endtask

  task automatic hostWrite(input logic [7:0] addr, input logic [15:0] v);
    @(negedge hostClk);
    hostWrEn = 1'b1; hostAddr = addr; hostWrData = v;
    @(negedge hostClk);
    hostWrEn = 1'b0; hostAddr = 8'h08;
  endtask

  task automatic waitIdle();
    int guard = 0;
    @(negedge hostClk);
    while (hostBusy && guard < 400) begin
      @(negedge hostClk);
      guard++;
    end
  endtask

  task automatic markId(input logic withTick);
    @(negedge busClk);
    idStart = 1'b1; bitTick = withTick;
    @(negedge busClk);
    idStart = 1'b0; bitTick = 1'b0;
  endtask

  // Driver: push the expected stamp, then pulse frame completion
  task automatic frameDone(input logic [15:0] expStamp, input logic withId);
    expQ.push_back(expStamp);
    stampsPushed++;
    @(negedge busClk);
    frameOk = 1'b1; idStart = withId;
    @(negedge busClk);
    frameOk = 1'b0; idStart = 1'b0;
    repeat (2) @(negedge busClk);
  endtask

  // Monitor: pop and compare each presented stamp (R6)
  initial begin
    forever begin
      @(negedge busClk);
      if (rstN && stampValid) begin
        stampsSeen++;
        if (expQ.size() == 0) check("R6 unexpected stamp", {16'h0, stampOut}, 32'hDEAD);
        else check("R5/R6 stamp value", {16'h0, stampOut}, {16'h0, expQ.pop_front()});
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    #400000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] rd;
    repeat (5) @(negedge hostClk);
    rstN = 1'b1;

    // R1 reset state
    readReg(8'h08, rd);
    check("R1 count after reset", rd, 32'h0);
    check("R1 busy after reset", {31'h0, hostBusy}, 32'h0);
    check("R1 stampValid after reset", {31'h0, stampValid}, 32'h0);
    check("R1 stampOut after reset", {16'h0, stampOut}, 32'h0);

    // R2 counting, R9 upper half zero
    ticks(5);
    readReg(8'h08, rd);
    check("R2 count after 5 ticks", rd, 32'h5);

    // R4 freeze holds
    freeze = 1'b1;
    ticks(7);
    readReg(8'h08, rd);
    check("R4 frozen count", rd, 32'h5);
    freeze = 1'b0;

    // R5 capture, R6 publish
    markId(1'b0);               // latch 5
    ticks(3);                   // count 8
    frameDone(16'h0005, 1'b0);
    markId(1'b1);               // latch 8, count 9
    frameDone(16'h0008, 1'b0);
    frameDone(16'h0008, 1'b1);  // R6 old stamp out, latch 9
    frameDone(16'h0009, 1'b0);
    readReg(8'h08, rd);
    check("R5 count after capture ticks", rd, 32'h9);
    check("R6 stampValid idle", {31'h0, stampValid}, 32'h0);

    // R7 write with handshake, R8 second write ignored
    hostWrite(8'h08, 16'hFFFD);
    check("R7 busy after write", {31'h0, hostBusy}, 32'h1);
    hostWrite(8'h08, 16'h1234);
    waitIdle();
    check("R7 busy cleared", {31'h0, hostBusy}, 32'h0);
    readReg(8'h08, rd);
    check("R7 R8 written value", rd, 32'h0000FFFD);

    // R3 wrap
    ticks(3);
    readReg(8'h08, rd);
    check("R3 wrapped count", rd, 32'h0);
    ticks(1);
    readReg(8'h08, rd);
    check("R3 count after wrap", rd, 32'h1);

    // R9 other address
    hostWrite(8'h04, 16'h7777);
    check("R9 busy on wrong address", {31'h0, hostBusy}, 32'h0);
    readReg(8'h04, rd);
    check("R9 read wrong address", rd, 32'h0);
    readReg(8'h08, rd);
    check("R9 count after wrong write", rd, 32'h1);

    // R11 load during freeze
    freeze = 1'b1;
    hostWrite(8'h08, 16'h00AA);
    waitIdle();
    ticks(2);
    readReg(8'h08, rd);
    check("R11 load in freeze", rd, 32'h00AA);
    freeze = 1'b0;

    // R10 load with continuous ticks
    @(negedge busClk);
    bitTick = 1'b1;
    hostWrite(8'h08, 16'h4000);
    waitIdle();
    @(negedge busClk);
    bitTick = 1'b0;
    readReg(8'h08, rd);
    testsRun++;
    if (rd < 32'h4000 || rd > 32'h4040) begin
      testsFailed++;
      $display("FAIL R10 load under ticks: actual %h expected 4000..4040", rd);
    end

    repeat (4) @(negedge busClk);
    check("R6 stamps presented", stampsSeen, stampsPushed);
    check("R6 queue drained", expQ.size(), 0);
    finishRun();
  end

endmodule